// File: doc/BRIEF.md
# Receive Bit Clock Recovery Loop

This block recovers the bit timing of a serial receive stream whose bits have already been hard-decided by a demodulator. It runs on the system sampling clock and produces two outputs. The first is a regenerated bit clock. The second is the data retimed to that clock. A select input sets one of two bit rates, and the slow rate has twice the bit period of the fast one.

Each bit period is divided into sixteen phase steps. A free-running phase counter advances one step per prescaler tick, and its top bit forms the recovered clock. A data transition that arrives while the counter sits in the first half of the bit holds the counter back by one step. A transition in the second half pushes it forward by one step. A transition at phase zero leaves it alone. The received level is captured at the rising edge of the recovered clock, which falls at mid-bit. The captured value is presented just after the next falling edge, so downstream logic can latch it on the rising edge.

A synchronous clear puts the loop in its idle state while the receiver is switched off. The asynchronous reset has the same effect.

Top module: `rx_bit_dpll`

## Requirements
- R1: While `rst_n` is low, `rx_clk_o` and `rx_data_o` are both 0.
- R2: While `clr` is high, `rx_clk_o` and `rx_data_o` are 0 from the following clock cycle onward, whatever `rx_bit_i` does.
- R3: With no transitions on `rx_bit_i`, `rx_clk_o` has a period of 16 phase steps and is high for exactly half of it. A phase step is STEP_DIV clock cycles when `rate_sel` = 1 (fast rate) and 2*STEP_DIV clock cycles when `rate_sel` = 0 (slow rate).
- R4: A single transition seen while the loop is in phases 1 to 7 (first half of the bit, counted from the falling edge of `rx_clk_o`) delays the following edge of `rx_clk_o` by exactly one phase step.
- R5: A single transition seen while the loop is in phases 8 to 15 (second half of the bit) brings the following edge of `rx_clk_o` forward by exactly one phase step.
- R6: Take an alternating 1/0 preamble and any starting phase. At the transition that starts the 12th bit (after 11 bits), the nearest falling edge of `rx_clk_o` lies within a quarter bit period plus 4 clock cycles of that transition.
- R7: With the same preamble, at the transition that starts the 19th bit (after 18 bits), the nearest falling edge of `rx_clk_o` lies within one phase step plus 4 clock cycles of that transition.
- R8: `rx_data_o` changes value only in the clock cycle right after a falling edge of `rx_clk_o`, or as the result of a clear.
- R9: `rx_data_o` carries the level of `rx_bit_i` sampled at the rising edge of `rx_clk_o`. Once the loop is locked, latching `rx_data_o` on successive rising edges of `rx_clk_o` yields the transmitted bits in order, first bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous loop clear, active high |
| rate_sel | input | 1 | 1 selects the fast bit rate, 0 the slow bit rate |
| rx_bit_i | input | 1 | Hard-decided receive data |
| rx_clk_o | output | 1 | Recovered bit clock; rises at mid-bit |
| rx_data_o | output | 1 | Retimed receive data |

## Verification
The bench builds the loop with STEP_DIV = 3, which gives a fast bit period of 48 cycles and a slow bit period of 96 cycles. The default prescaler would need thousands of cycles per bit. With the short periods, the 20-bit lock-in runs at both rates, the worst-case half-bit starting offset, and whole payload frames all fit in a few thousand cycles. A phase step of three cycles still leaves the one-step advance and retard visible, and the bench measures each as an exact cycle count.

// File: rtl/rx_bit_dpll_pkg.sv
package rx_bit_dpll_pkg;
    typedef enum logic [1:0] {
        NUDGE_NONE = 2'd0,
        NUDGE_FWD  = 2'd1,
        NUDGE_BACK = 2'd2
    } nudge_e;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic dsync,
    output logic edge_p
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   last;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            s_d.sh   = {s_q.sh[SYNC_STAGES-2:0], din};
            s_d.last = s_q.sh[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dsync  = s_q.sh[SYNC_STAGES-1];
    assign edge_p = s_q.sh[SYNC_STAGES-1] ^ s_q.last;
endmodule

// File: rtl/step_prescaler.sv
module step_prescaler #(
    parameter int STEP_DIV = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rate_sel,
    output logic tick
);
    localparam int CW = $clog2(2 * STEP_DIV) + 1;
    localparam logic [CW-1:0] LIM_FAST = CW'(STEP_DIV - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(2 * STEP_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t p_q, p_d;
    logic [CW-1:0] limit;

    always_comb begin
        limit = rate_sel ? LIM_FAST : LIM_SLOW;
        tick  = (p_q.cnt >= limit);
        p_d   = p_q;
        if (clr)       p_d.cnt = '0;
        else if (tick) p_d.cnt = '0;
        else           p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/phase_track.sv
module phase_track
    import rx_bit_dpll_pkg::*;
#(
    parameter int PHASES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       tick,
    input  logic                       edge_p,
    output logic [$clog2(PHASES)-1:0]  phase
);
    localparam int PH_W = $clog2(PHASES);
    localparam logic [PH_W-1:0] HALF = PH_W'(PHASES / 2);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        nudge_e          nudge;
    } trk_t;

    trk_t t_q, t_d;
    nudge_e          seen;
    logic [PH_W-1:0] stride;

    always_comb begin
        // direction implied by where a transition lands in the bit
        if (t_q.ph == '0)      seen = NUDGE_NONE;
        else if (t_q.ph < HALF) seen = NUDGE_BACK;
        else                    seen = NUDGE_FWD;

        case (t_q.nudge)
            NUDGE_FWD:  stride = PH_W'(2);
            NUDGE_BACK: stride = '0;
            default:    stride = PH_W'(1);
        endcase

        t_d = t_q;
        if (clr) begin
            t_d = '{ph: '0, nudge: NUDGE_NONE};
        end else begin
            if (tick) t_d.ph = t_q.ph + stride;
            if (edge_p)    t_d.nudge = seen;
            else if (tick) t_d.nudge = NUDGE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{ph: '0, nudge: NUDGE_NONE};
        else        t_q <= t_d;
    end

    assign phase = t_q.ph;
endmodule

// File: rtl/bit_retimer.sv
module bit_retimer (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic phase_msb,
    input  logic dsync,
    output logic rx_data
);
    typedef struct packed {
        logic msb_prev;
        logic smp;
        logic dat;
    } ret_t;

    ret_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else begin
            r_d.msb_prev = phase_msb;
            if (phase_msb && !r_q.msb_prev) r_d.smp = dsync;
            if (!phase_msb && r_q.msb_prev) r_d.dat = r_q.smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data = r_q.dat;
endmodule

// File: rtl/rx_bit_dpll.sv
module rx_bit_dpll #(
    parameter int STEP_DIV    = 96,
    parameter int PHASES      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rate_sel,
    input  logic rx_bit_i,
    output logic rx_clk_o,
    output logic rx_data_o
);
    localparam int PH_W = $clog2(PHASES);

    logic            dsync;
    logic            edge_p;
    logic            tick;
    logic [PH_W-1:0] phase;

    rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(clr), .din(rx_bit_i),
        .dsync(dsync), .edge_p(edge_p)
    );

    step_prescaler #(.STEP_DIV(STEP_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rate_sel(rate_sel), .tick(tick)
    );

    phase_track #(.PHASES(PHASES)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .edge_p(edge_p),
        .phase(phase)
    );

    bit_retimer u_ret (
        .clk(clk), .rst_n(rst_n), .clr(clr), .phase_msb(phase[PH_W-1]),
        .dsync(dsync), .rx_data(rx_data_o)
    );

    assign rx_clk_o = phase[PH_W-1];
endmodule

module rx_bit_dpll_chk #(
    parameter int STEP_DIV = 96
) (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic rx_clk_o,
    input logic rx_data_o
);
    // longest legal constant level: 8 slow steps plus one retarded step
    localparam int RUN_MAX = 18 * STEP_DIV + 2;
    localparam int RW      = $clog2(RUN_MAX + 2) + 1;

    logic [RW-1:0] run_q;
    logic          clk_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            clk_seen_q <= 1'b0;
        end else begin
            clk_seen_q <= rx_clk_o;
            if (clr || rx_clk_o != clk_seen_q) run_q <= '0;
            else if (run_q <= RW'(RUN_MAX)) run_q <= run_q + 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (rx_clk_o == 1'b0 && rx_data_o == 1'b0)
                else $error("R1 outputs not idle in reset");
        end
    end

    a_r2_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rx_clk_o && !rx_data_o));

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RUN_MAX));

    a_r8_data_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && rx_data_o != $past(rx_data_o))
            |-> (!$past(rx_clk_o) && $past(rx_clk_o, 2)));
endmodule

bind rx_bit_dpll rx_bit_dpll_chk #(.STEP_DIV(STEP_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rx_clk_o(rx_clk_o), .rx_data_o(rx_data_o)
);

// File: tb/rx_bit_dpll_test.sv
module rx_bit_dpll_test;
    localparam int DIV   = 3;
    localparam int FASTP = 16 * DIV;
    localparam int SLOWP = 32 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic rate_sel = 1'b1;
    logic rx_bit = 1'b0;
    logic rx_clk_o, rx_data_o;

    always #4 clk = ~clk;

    rx_bit_dpll #(.STEP_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rate_sel(rate_sel),
        .rx_bit_i(rx_bit), .rx_clk_o(rx_clk_o), .rx_data_o(rx_data_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // output monitor: falling-edge times, stream latched at rising edges, R8 watch
    logic         m_clk = 1'b0, m_dat = 1'b0, m_clr = 1'b0;
    int           last_fall = -1000;
    logic [127:0] stream = '0;
    int           r8_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_clk && !rx_clk_o) last_fall = cyc;
            if (!m_clk && rx_clk_o) stream = {stream[126:0], rx_data_o};
            if (rx_data_o != m_dat && !clr && !m_clr && last_fall != cyc - 1) r8_bad++;
        end
        m_clk = rx_clk_o;
        m_dat = rx_data_o;
        m_clr = clr;
    end

    task automatic count_until(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rx_clk_o !== lvl);
    endtask

    task automatic restart(input logic rate);
        @(negedge clk);
        clr = 1'b1;
        rate_sel = rate;
        rx_bit = 1'b0;
        repeat (4) @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(rx_clk_o == 1'b0, "R1 clock in reset", rx_clk_o, 0);
        chk(rx_data_o == 1'b0, "R1 data in reset", rx_data_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clear;
        int bad = 0;
        restart(1'b1);
        rx_bit = 1'b1;
        repeat (3 * FASTP) @(negedge clk);
        chk(rx_data_o == 1'b1, "R9 steady one recovered", rx_data_o, 1);
        clr = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i % 5 == 0) rx_bit = ~rx_bit;
            if (rx_clk_o || rx_data_o) bad++;
        end
        clr = 1'b0;
        chk(bad == 0, "R2 outputs idle under clear", bad, 0);
    endtask

    task automatic t_period(input logic rate);
        int d, hi, lo;
        int p = rate ? FASTP : SLOWP;
        restart(rate);
        count_until(1'b1, d);
        count_until(1'b0, hi);
        count_until(1'b1, lo);
        chk(hi == p / 2, "R3 high time", hi, p / 2);
        chk(hi + lo == p, "R3 period", hi + lo, p);
    endtask

    task automatic t_retard;
        int d, n;
        restart(1'b1);
        count_until(1'b1, d);
        count_until(1'b0, d);
        repeat (12) @(negedge clk);
        rx_bit = ~rx_bit;
        count_until(1'b1, n);
        chk(n + 12 == FASTP / 2 + DIV, "R4 early-half transition delays edge", n + 12, FASTP / 2 + DIV);
    endtask

    task automatic t_advance;
        int d, n;
        restart(1'b1);
        count_until(1'b1, d);
        count_until(1'b0, d);
        repeat (36) @(negedge clk);
        rx_bit = ~rx_bit;
        count_until(1'b0, n);
        chk(n + 36 == FASTP - DIV, "R5 late-half transition advances edge", n + 36, FASTP - DIV);
    endtask

    task automatic t_lock(input logic rate, input int off);
        int p = rate ? FASTP : SLOWP;
        restart(rate);
        repeat (off) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            int t0, err;
            rx_bit = (k % 2 == 0);
            t0 = cyc;
            repeat (p / 2) @(negedge clk);
            err = last_fall - t0;
            if (err < 0) err = -err;
            if (k == 11) chk(err <= p / 4 + 4, "R6 phase error after 11 bits", err, p / 4 + 4);
            if (k == 18) chk(err <= p / 16 + 4, "R7 phase error after 18 bits", err, p / 16 + 4);
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic t_payload(input logic rate, input logic [15:0] pay);
        int p = rate ? FASTP : SLOWP;
        bit found = 1'b0;
        restart(rate);
        for (int k = 0; k < 20; k++) begin
            rx_bit = (k % 2 == 0);
            repeat (p) @(negedge clk);
        end
        for (int k = 15; k >= 0; k--) begin
            rx_bit = pay[k];
            repeat (p) @(negedge clk);
        end
        rx_bit = 1'b0;
        repeat (6 * p) @(negedge clk);
        for (int k = 0; k <= 48; k++)
            if (stream[k +: 16] == pay) found = 1'b1;
        chk(found, "R9 payload recovered in order", int'(stream[15:0]), int'(pay));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clear();
        t_period(1'b1);
        t_period(1'b0);
        t_retard();
        t_advance();
        t_lock(1'b1, 0);
        t_lock(1'b1, FASTP / 2);
        t_lock(1'b0, SLOWP / 2 + DIV);
        t_payload(1'b1, 16'hE269);
        t_payload(1'b0, 16'h3A5C);
        chk(r8_bad == 0, "R8 data changes only after a falling edge", r8_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule